// File: doc/BRIEF.md
# SPI Master Controller with Transmit and Receive FIFOs

This block is a register-mapped synchronous serial controller that drives the serial clock, the outbound data line and an active-low chip select. It uses the common SPI frame format and works as a master only. Software or a DMA engine writes data words into an 8-entry transmit FIFO through a small register bus. The shifter sends each word most significant bit first. At the same time it captures the inbound data line into an 8-entry receive FIFO, which is read back through the same data register.

The serial clock comes from two dividers in series: an even prescaler and a post-divider. One frame carries 4 to 16 bits. Both clock polarity and clock phase are programmable. When the receive FIFO is full, each frame that completes is dropped and the shifter keeps running. A dropped frame sets a sticky overrun flag, and only a write to the clear register removes it. Two request lines pace a DMA engine, one for transmit and one for receive.

Register map (word address on `reg_addr`):
- 0 format: bits [3:0] frame length minus one; bit 4 clock polarity (idle level of `spi_clk`); bit 5 clock phase (0: sample on the leading edge, 1: sample on the trailing edge); bits [15:8] post-divide value SCR.
- 1 control: bit 0 enable; bit 1 target-mode select (shifting only happens with enable=1 and this bit=0).
- 2 data: a write pushes to the transmit FIFO, a read pops from the receive FIFO.
- 3 status (read only): bit 0 transmit not full; bit 1 receive not empty; bit 2 busy; bit 3 receive overrun.
- 4 prescale: bits [7:0]. Bit 0 is ignored, and a value below 2 acts as 2.
- 5 clear (write only): writing bit 0 as 1 clears the overrun flag.
- 6 DMA: bit 0 transmit request enable; bit 1 receive request enable.

Top module: `spi_fifo_master`

## Requirements
- R1: The frame holds (format[3:0] + 1) bits, from 4 to 16. Only that many low bits of a transmit word are sent. A received word carries the frame's bits in its low bits, and its upper bits read as zero.
- R2: One serial bit lasts P × (SCR + 1) clock cycles, where P is the prescale value with bit 0 forced to zero and with 0 treated as 2.
- R3: Bits go out on `spi_mosi` and are collected from `spi_miso` most significant bit first.
- R4: With the polarity bit at 0 or 1 and the phase bit at 0 or 1, all four modes transfer data correctly. When no frame is active, `spi_clk` sits at the polarity bit.
- R5: Each FIFO holds 8 words. A write to the data register while the transmit FIFO is full is ignored.
- R6: Status bit 0 is 1 while the transmit FIFO has room and bit 1 is 1 while the receive FIFO has data. Bit 2 is 1 while a frame is shifting or while shifting is permitted and the transmit FIFO is not empty. After reset the status reads 0x0001.
- R7: `spi_cs_n` goes low when the first frame of a burst starts. It stays low through back-to-back frames and returns high only after the transmit FIFO is empty and the last frame has finished.
- R8: When a frame completes while the receive FIFO is full, that frame is dropped, the stored words are kept, and status bit 3 is set. Bit 3 stays set until bit 0 of the clear register is written as 1.
- R9: `dma_tx_req` is 1 exactly when DMA bit 0 is set and the transmit FIFO is not full. `dma_rx_req` is 1 exactly when DMA bit 1 is set and the receive FIFO is not empty.
- R10: No frame starts while the enable bit is 0 or the target-mode bit is 1. In that state `spi_cs_n` stays high.
- R11: Reading the data register while the receive FIFO is empty returns 0 and changes no FIFO state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at the data address) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the strobe cycle |
| spi_clk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The properties assume that the format, prescale and control registers are not rewritten while a frame is shifting, and that `spi_miso` changes only when the bench's loopback path follows `spi_mosi`. The bench keeps to these assumptions. It programs each configuration with shifting disabled, loads the transmit FIFO, sets the enable bit, and touches no configuration register again until the status busy bit and chip select report idle. Strobes are single-cycle and are driven half a cycle away from the active edge.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int unsigned RA_W = 3;

   localparam logic [RA_W-1:0] RA_FORMAT = 3'd0;
   localparam logic [RA_W-1:0] RA_CTRL   = 3'd1;
   localparam logic [RA_W-1:0] RA_DATA   = 3'd2;
   localparam logic [RA_W-1:0] RA_STAT   = 3'd3;
   localparam logic [RA_W-1:0] RA_PRESC  = 3'd4;
   localparam logic [RA_W-1:0] RA_CLEAR  = 3'd5;
   localparam logic [RA_W-1:0] RA_DMA    = 3'd6;

   localparam int unsigned FMT_CPOL = 4;
   localparam int unsigned FMT_CPHA = 5;
   localparam int unsigned FMT_SCR  = 8;

   localparam int unsigned ST_TNF  = 0;
   localparam int unsigned ST_RNE  = 1;
   localparam int unsigned ST_BUSY = 2;
   localparam int unsigned ST_OVR  = 3;

   typedef enum logic {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     pop,
   input  logic [WIDTH-1:0]         din,
   output logic [WIDTH-1:0]         dout,
   output logic                     full,
   output logic                     empty,
   output logic [$clog2(DEPTH):0]   count
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH) + 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign do_push = push && (cnt != CW'(DEPTH));
   assign do_pop  = pop  && (cnt != '0);

   logic [PW-1:0] wptr_nx, rptr_nx;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
   end else begin : g_wrap
      assign wptr_nx = (wptr == LAST) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == LAST) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   assign dout  = mem[rptr];
   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign count = cnt;
endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
   parameter int unsigned PREW = 8,
   parameter int unsigned SCRW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PREW-2:0] pre_half,
   input  logic [SCRW-1:0] scr,
   output logic            tick
);
   if (PREW < 2) begin : g_bad_prew
      $error("spim_baud: PREW must be at least 2");
   end

   logic [PREW-2:0] pcnt;
   logic [SCRW-1:0] scnt;
   logic            pre_wrap, scr_wrap;

   assign pre_wrap = (pcnt == (pre_half - 1'b1));
   assign scr_wrap = (scnt == scr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         scnt <= '0;
      end else if (!run) begin
         pcnt <= '0;
         scnt <= '0;
      end else if (pre_wrap) begin
         pcnt <= '0;
         scnt <= scr_wrap ? '0 : scnt + 1'b1;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end

   assign tick = run && pre_wrap && scr_wrap;
endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int unsigned DW = 16,
   localparam int unsigned SW = $clog2(DW),
   localparam int unsigned EW = SW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] size_m1,
   input  logic          cpol,
   input  logic          cpha,
   input  logic          run_ok,
   input  logic          tick,
   input  logic          tx_empty,
   input  logic [DW-1:0] tx_word,
   output logic          tx_pop,
   output logic          rx_push,
   output logic [DW-1:0] rx_word,
   input  logic          miso,
   output logic          sck,
   output logic          mosi,
   output logic          active
);
   eng_state_t    st;
   logic [EW-1:0] edge_cnt;
   logic [SW-1:0] out_idx;
   logic [DW-1:0] word_q;
   logic [DW-1:0] rx_sh;
   logic [DW-1:0] rx_full_word;
   logic [DW-1:0] mask;
   logic          lvl;
   logic          mosi_q;
   logic          leading, last_edge, start, reload;

   assign leading   = !edge_cnt[0];
   assign last_edge = (edge_cnt == {size_m1, 1'b1});
   assign start     = (st == ENG_IDLE) && run_ok && !tx_empty;
   assign reload    = (st == ENG_SHIFT) && tick && last_edge && run_ok && !tx_empty;
   assign tx_pop    = start || reload;
   assign rx_push   = (st == ENG_SHIFT) && tick && last_edge;
   assign mask      = {DW{1'b1}} >> (SW'(DW - 1) - size_m1);

   assign rx_full_word = cpha ? {rx_sh[DW-2:0], miso} : rx_sh;
   assign rx_word      = rx_full_word & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ENG_IDLE;
         edge_cnt <= '0;
         out_idx  <= '0;
         word_q   <= '0;
         rx_sh    <= '0;
         lvl      <= 1'b0;
         mosi_q   <= 1'b0;
      end else if (start) begin
         st       <= ENG_SHIFT;
         word_q   <= tx_word;
         out_idx  <= size_m1;
         edge_cnt <= '0;
         lvl      <= 1'b0;
         mosi_q   <= 1'b0;
         rx_sh    <= '0;
      end else if ((st == ENG_SHIFT) && tick) begin
         lvl      <= !lvl;
         edge_cnt <= edge_cnt + 1'b1;
         if (leading) begin
            if (cpha) begin
               mosi_q  <= word_q[out_idx];
               out_idx <= out_idx - 1'b1;
            end else begin
               rx_sh   <= {rx_sh[DW-2:0], miso};
            end
         end else begin
            if (cpha) begin
               rx_sh <= {rx_sh[DW-2:0], miso};
            end else if (!last_edge) begin
               out_idx <= out_idx - 1'b1;
            end
         end
         if (last_edge) begin
            edge_cnt <= '0;
            if (reload) begin
               word_q  <= tx_word;
               out_idx <= size_m1;
               rx_sh   <= '0;
            end else begin
               st      <= ENG_IDLE;
            end
         end
      end
   end

   assign active = (st == ENG_SHIFT);
   assign sck    = cpol ^ lvl;
   assign mosi   = !active ? 1'b0 : (cpha ? mosi_q : word_q[out_idx]);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spim_pkg::*;
#(
   parameter int unsigned DW         = 16,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned PREW       = 8,
   parameter int unsigned SCRW       = 8,
   localparam int unsigned SW        = $clog2(DW),
   localparam int unsigned CNTW      = $clog2(FIFO_DEPTH) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [2:0]      reg_addr,
   input  logic [15:0]     reg_wdata,
   output logic [15:0]     reg_rdata,
   output logic            spi_clk,
   output logic            spi_mosi,
   input  logic            spi_miso,
   output logic            spi_cs_n,
   output logic            dma_tx_req,
   output logic            dma_rx_req
);
   if (DW != 16) begin : g_bad_dw
      $error("spi_fifo_master: register layout assumes DW of 16");
   end
   if (FMT_SCR + SCRW > DW) begin : g_bad_scr
      $error("spi_fifo_master: post-divide field does not fit the format register");
   end
   if (PREW > DW) begin : g_bad_prew
      $error("spi_fifo_master: prescale wider than the bus");
   end

   logic [DW-1:0]   fmt_q;
   logic [1:0]      ctrl_q;
   logic [PREW-1:0] presc_q;
   logic [1:0]      dma_q;
   logic            ovr_q;

   logic            wr_fmt, wr_ctrl, wr_data, wr_presc, wr_clear, wr_dma, rd_data;

   assign wr_fmt   = reg_wr && (reg_addr == RA_FORMAT);
   assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
   assign wr_data  = reg_wr && (reg_addr == RA_DATA);
   assign wr_presc = reg_wr && (reg_addr == RA_PRESC);
   assign wr_clear = reg_wr && (reg_addr == RA_CLEAR) && reg_wdata[0];
   assign wr_dma   = reg_wr && (reg_addr == RA_DMA);
   assign rd_data  = reg_rd && (reg_addr == RA_DATA);

   logic [SW-1:0]   size_m1;
   logic            cpol, cpha, run_ok;
   logic [SCRW-1:0] scr;
   logic [PREW-2:0] pre_half;

   assign size_m1  = (fmt_q[SW-1:0] < SW'(3)) ? SW'(3) : fmt_q[SW-1:0];
   assign cpol     = fmt_q[FMT_CPOL];
   assign cpha     = fmt_q[FMT_CPHA];
   assign scr      = fmt_q[FMT_SCR +: SCRW];
   assign pre_half = (presc_q[PREW-1:1] == '0) ? (PREW-1)'(1) : presc_q[PREW-1:1];
   assign run_ok   = ctrl_q[0] && !ctrl_q[1];

   logic            tx_full, tx_empty, rx_full, rx_empty;
   logic [CNTW-1:0] tx_count, rx_count;
   logic [DW-1:0]   tx_head, rx_head, rx_word;
   logic            tx_pop, rx_push, active, tick;
   logic            rx_accept, rx_drop;

   assign rx_accept = rx_push && !rx_full;
   assign rx_drop   = rx_push && rx_full;

   spim_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_data), .pop(tx_pop), .din(reg_wdata),
      .dout(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_count)
   );

   spim_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_accept), .pop(rd_data), .din(rx_word),
      .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_count)
   );

   spim_baud #(.PREW(PREW), .SCRW(SCRW)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(active),
      .pre_half(pre_half), .scr(scr), .tick(tick)
   );

   spim_engine #(.DW(DW)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .size_m1(size_m1), .cpol(cpol), .cpha(cpha), .run_ok(run_ok),
      .tick(tick), .tx_empty(tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_word(rx_word), .miso(spi_miso),
      .sck(spi_clk), .mosi(spi_mosi), .active(active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q   <= '0;
         ctrl_q  <= '0;
         presc_q <= '0;
         dma_q   <= '0;
         ovr_q   <= 1'b0;
      end else begin
         if (wr_fmt)   fmt_q   <= reg_wdata;
         if (wr_ctrl)  ctrl_q  <= reg_wdata[1:0];
         if (wr_presc) presc_q <= reg_wdata[PREW-1:0];
         if (wr_dma)   dma_q   <= reg_wdata[1:0];
         if (rx_drop)       ovr_q <= 1'b1;
         else if (wr_clear) ovr_q <= 1'b0;
      end
   end

   logic busy;
   assign busy = active || (run_ok && !tx_empty);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_FORMAT: reg_rdata = fmt_q;
         RA_CTRL:   reg_rdata[1:0] = ctrl_q;
         RA_DATA:   reg_rdata = rx_empty ? '0 : rx_head;
         RA_STAT: begin
            reg_rdata[ST_TNF]  = !tx_full;
            reg_rdata[ST_RNE]  = !rx_empty;
            reg_rdata[ST_BUSY] = busy;
            reg_rdata[ST_OVR]  = ovr_q;
         end
         RA_PRESC:  reg_rdata[PREW-1:0] = presc_q;
         RA_DMA:    reg_rdata[1:0] = dma_q;
         default:   reg_rdata = '0;
      endcase
   end

   assign spi_cs_n   = !active;
   assign dma_tx_req = dma_q[0] && !tx_full;
   assign dma_rx_req = dma_q[1] && !rx_empty;
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CNTW = $clog2(DEPTH) + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n,
   input logic            sck,
   input logic            cpol,
   input logic            ovr,
   input logic            ovr_clr,
   input logic            busy,
   input logic            run_ok,
   input logic            dma_tx_req,
   input logic            dma_rx_req,
   input logic            tx_dma_en,
   input logic            rx_dma_en,
   input logic [CNTW-1:0] tx_count,
   input logic [CNTW-1:0] rx_count
);
   AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (sck == cpol)); // R4
   AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_count <= CNTW'(DEPTH)); // R5
   AST_TX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_count <= CNTW'(DEPTH)); // R5
   AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy); // R7
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovr && !ovr_clr) |=> ovr); // R8
   AST_TX_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n) dma_tx_req |-> (tx_dma_en && tx_count < CNTW'(DEPTH))); // R9
   AST_RX_REQ_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rx_dma_en && rx_count != '0) |-> dma_rx_req); // R9
   AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (cs_n && !run_ok) |=> cs_n); // R10
endmodule

bind spi_fifo_master spim_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_clk), .cpol(cpol),
   .ovr(ovr_q), .ovr_clr(wr_clear), .busy(busy), .run_ok(run_ok),
   .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
   .tx_dma_en(dma_q[0]), .rx_dma_en(dma_q[1]),
   .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/sim_spi_fifo_master.sv
`timescale 1ns/1ps
module sim_spi_fifo_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        spi_clk, spi_mosi, spi_miso, spi_cs_n, dma_tx_req, dma_rx_req;
   logic        inv_q = 1'b0;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int cs_rises = 0;
   int sck_rises = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(posedge spi_cs_n) cs_rises++;
   always @(posedge spi_clk) sck_rises++;

   assign spi_miso = spi_mosi ^ inv_q;

   spi_fifo_master u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_clk(spi_clk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
   );

   typedef struct packed {
      logic        cpol;
      logic        cpha;
      logic [3:0]  size_m1;
      logic [7:0]  presc;
      logic [7:0]  scr;
      logic        inv;
      logic [15:0] word;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 1'b0, 4'd7,  8'd2, 8'd0, 1'b0, 16'h00A5},
      '{1'b0, 1'b1, 4'd7,  8'd2, 8'd1, 1'b1, 16'h003C},
      '{1'b1, 1'b0, 4'd15, 8'd4, 8'd0, 1'b0, 16'hBEEF},
      '{1'b1, 1'b1, 4'd3,  8'd2, 8'd0, 1'b1, 16'h0009},
      '{1'b0, 1'b0, 4'd3,  8'd2, 8'd0, 1'b0, 16'hFFF5},
      '{1'b1, 1'b1, 4'd15, 8'd2, 8'd2, 1'b0, 16'h8001},
      '{1'b0, 1'b1, 4'd11, 8'd6, 8'd0, 1'b1, 16'h0ABC},
      '{1'b1, 1'b0, 4'd8,  8'd2, 8'd0, 1'b0, 16'h0155}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      s = 16'h0004;
      while (s[2] || !spi_cs_n) bus_read(3'd3, s);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      while (cyc < 150000 && !done) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
      end
   end

   initial begin
      logic [15:0] r, m, exp;
      int t0, t1, n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 reset state
      bus_read(3'd3, r); check("R6 reset status", r, 16'h0001);
      bus_read(3'd0, r); check("R6 reset format", r, 16'h0000);
      check("R7 reset cs_n", spi_cs_n, 1'b1);
      check("R4 reset clk idle", spi_clk, 1'b0);
      // R11 empty read
      bus_read(3'd2, r); check("R11 empty read", r, 16'h0000);
      bus_read(3'd3, r); check("R11 status unchanged", r, 16'h0001);

      // Vector table: R1 R3 R4 loopback
      foreach (VEC[i]) begin
         bus_write(3'd1, 16'h0000);
         bus_write(3'd0, {VEC[i].scr, 2'b00, VEC[i].cpha, VEC[i].cpol, VEC[i].size_m1});
         bus_write(3'd4, {8'h00, VEC[i].presc});
         inv_q = VEC[i].inv;
         bus_write(3'd2, VEC[i].word);
         bus_write(3'd1, 16'h0001);
         wait_idle();
         m   = 16'hFFFF >> (4'd15 - VEC[i].size_m1);
         exp = (VEC[i].word ^ {16{VEC[i].inv}}) & m;
         bus_read(3'd2, r); check("R1 R3 R4 loopback word", r, exp);
         check("R4 idle clk level", spi_clk, VEC[i].cpol);
      end
      inv_q = 1'b0;

      // R2 bit period: prescale 7 acts as 6, SCR 2 -> 18 cycles
      bus_write(3'd1, 16'h0000);
      bus_write(3'd0, {8'd2, 8'h07});
      bus_write(3'd4, 16'd7);
      bus_write(3'd2, 16'h0033);
      bus_write(3'd1, 16'h0001);
      @(posedge spi_clk); t0 = cyc;
      @(posedge spi_clk); t1 = cyc;
      check("R2 bit period", t1 - t0, 18);
      bus_read(3'd3, r); check("R6 busy while shifting", r[2], 1'b1);
      wait_idle();
      bus_read(3'd2, r); check("R2 data after slow frame", r, 16'h0033);

      // R2 prescale 0 acts as 2, SCR 0 -> 2 cycles
      bus_write(3'd1, 16'h0000);
      bus_write(3'd4, 16'd0);
      bus_write(3'd0, 16'h0007);
      bus_write(3'd2, 16'h0055);
      bus_write(3'd1, 16'h0001);
      @(posedge spi_clk); t0 = cyc;
      @(posedge spi_clk); t1 = cyc;
      check("R2 minimum prescale", t1 - t0, 2);
      wait_idle();
      bus_read(3'd2, r);

      // R7 burst of three: one cs rise, 24 clock pulses
      bus_write(3'd1, 16'h0000);
      bus_write(3'd4, 16'd4);
      for (int k = 0; k < 3; k++) bus_write(3'd2, 16'h0010 + 16'(k));
      n0 = cs_rises; t0 = sck_rises;
      bus_write(3'd1, 16'h0001);
      wait_idle();
      check("R7 single select burst", cs_rises - n0, 1);
      check("R1 clock pulses in burst", sck_rises - t0, 24);
      for (int k = 0; k < 3; k++) begin
         bus_read(3'd2, r); check("R7 burst data", r, 16'h0010 + 16'(k));
      end

      // R5 and R9 fill transmit FIFO while disabled
      bus_write(3'd1, 16'h0000);
      bus_write(3'd6, 16'h0003);
      check("R9 tx request with room", dma_tx_req, 1'b1);
      check("R9 rx request idle", dma_rx_req, 1'b0);
      for (int k = 0; k < 8; k++) bus_write(3'd2, 16'h0040 + 16'(k));
      bus_read(3'd3, r); check("R5 tx full status", r[0], 1'b0);
      check("R9 tx request full", dma_tx_req, 1'b0);
      bus_write(3'd2, 16'h00EE);
      // R10 disabled: nothing shifts
      repeat (40) @(negedge clk);
      check("R10 cs stays high disabled", spi_cs_n, 1'b1);
      bus_write(3'd1, 16'h0003);
      repeat (40) @(negedge clk);
      check("R10 cs stays high target mode", spi_cs_n, 1'b1);
      bus_read(3'd3, r); check("R10 status no rx no busy", r, 16'h0000);
      bus_write(3'd1, 16'h0001);
      wait_idle();
      bus_read(3'd3, r); check("R5 rx full, no overrun", r, 16'h0003);
      check("R9 rx request", dma_rx_req, 1'b1);

      // R8 overrun: one more frame with receive FIFO full
      bus_write(3'd2, 16'h00AA);
      wait_idle();
      bus_read(3'd3, r); check("R8 overrun set", r[3], 1'b1);
      bus_read(3'd2, r); check("R8 oldest kept", r, 16'h0040);
      bus_read(3'd3, r); check("R8 overrun sticky after read", r[3], 1'b1);
      for (int k = 1; k < 8; k++) begin
         bus_read(3'd2, r); check("R5 ninth write dropped", r, 16'h0040 + 16'(k));
      end
      bus_read(3'd3, r); check("R8 rx empty after drain", r[1], 1'b0);
      check("R9 rx request empty", dma_rx_req, 1'b0);
      bus_write(3'd5, 16'h0001);
      bus_read(3'd3, r); check("R8 overrun cleared", r, 16'h0001);

      done = 1'b1;
      summary();
   end
endmodule